// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This unit is the trap controller of a small 32-bit RISC core. Each cycle it looks at one-cycle requests for a breakpoint, a data bus error (raised for both unmapped and misaligned accesses), a divide by zero and a system call. It also looks at the pending external interrupts. When one of these is taken, it produces a redirect to the handler in the same cycle, and it writes the PC of the faulting instruction back into a dedicated general register.

On the same clock edge it updates its interrupt-enable register. The live enable bit is moved into a shadow bit that belongs to the event class, and the live enable is cleared. A branch through either return register later restores the live enable from that class's shadow bit.

The unit holds five control registers:
- the interrupt enable;
- the interrupt mask;
- the interrupt pending bits, which are write-one-to-clear;
- the exception base;
- the debug base.

Software reads these registers through a combinational read port and writes them through a single write port. Handlers are placed at a fixed 32-byte stride from one of the two bases.

Top module: `trap_unit`

## Requirements
- R1: After reset the five control registers read 0 (select codes: 0 enable, 1 mask, 2 pending, 3 exception base, 4 debug base), and redirectValid and rfWe are low.
- R2: A taken data bus error, divide by zero or system call raises redirectValid and rfWe in the same cycle. redirectPc is the exception base plus id×32, with id 4, 5 and 7 respectively. rfAddr is 30 and rfData is faultPc.
- R3: A taken breakpoint gives redirectPc equal to the debug base plus 32 (id 1), with rfAddr 31 and rfData equal to faultPc.
- R4: After a non-debug trap (bus error, divide by zero, system call, interrupt), the enable register holds the old bit 0 in bit 1, and bits 0 and 2 are cleared.
- R5: After a breakpoint, the enable register holds the old bit 0 in bit 2, and bits 0 and 1 are cleared.
- R6: retExc (a branch through register 30) sets the enable register to the old bit 1 in bit 0. retBrk (a branch through register 31) sets it to the old bit 2 in bit 0. No redirect is produced in either case.
- R7: Writing the pending register clears every bit whose write-data bit is 1 and leaves the others unchanged. A high irqLines bit sets its pending bit on the next edge. Writes to the enable, mask and base registers replace their contents.
- R8: The exception base and debug base always read with bits 7:0 equal to zero, whatever was written.
- R9: An interrupt is taken, with id 6, redirectPc equal to the exception base plus 0xC0 and rfAddr 30, only when enable bit 0 is 1 and pending AND mask is nonzero.
- R10: When several events are requested in one cycle, exactly one is taken, in the order breakpoint, bus error, divide by zero, system call, interrupt.
- R11: If a trap is taken in the same cycle as a write to the enable register or a return, the trap's enable update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evBreak | input | 1 | Breakpoint request |
| evBusErr | input | 1 | Data bus error request (unmapped or misaligned) |
| evDivZero | input | 1 | Divide-by-zero request |
| evSyscall | input | 1 | System call request |
| faultPc | input | 32 | PC of the instruction in this cycle |
| irqLines | input | 8 | External interrupt lines, set pending bits |
| retExc | input | 1 | Branch through register 30 |
| retBrk | input | 1 | Branch through register 31 |
| csrWe | input | 1 | Control register write strobe |
| csrSel | input | 3 | Control register select |
| csrWdata | input | 32 | Control register write data |
| csrRdata | output | 32 | Selected control register value |
| redirectValid | output | 1 | Trap taken this cycle |
| redirectPc | output | 32 | Handler address |
| rfWe | output | 1 | Register-file write of the saved PC |
| rfAddr | output | 5 | Destination register (30 or 31) |
| rfData | output | 32 | Saved PC |

## Verification
A trap and a write to the enable register can fall in the same cycle. The bench provokes this by raising a divide by zero while it writes 0 to the enable register, and then judges by reading the register back. It must show the saved-enable pattern, not the written value. The bench also stacks several trap requests in one cycle, and raises an interrupt while the enable is off or the mask is clear. In each case it checks that only the highest-priority vector and register target appear.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    EXC_RESET   = 3'd0,
    EXC_BREAK   = 3'd1,
    EXC_IBUS    = 3'd2,
    EXC_WATCH   = 3'd3,
    EXC_DBUS    = 3'd4,
    EXC_DIVZERO = 3'd5,
    EXC_IRQ     = 3'd6,
    EXC_SYSCALL = 3'd7
  } excid_t;

  typedef enum logic [2:0] {
    CSR_IE   = 3'd0,
    CSR_IM   = 3'd1,
    CSR_IP   = 3'd2,
    CSR_EBA  = 3'd3,
    CSR_DEBA = 3'd4
  } csrsel_t;

  typedef struct packed {
    logic   take;
    logic   debug;
    excid_t excId;
    logic   retExc;
    logic   retBrk;
  } strobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    evBreak,
  input  logic    evBusErr,
  input  logic    evDivZero,
  input  logic    evSyscall,
  input  logic    ieLive,
  input  logic    irqPend,
  input  logic    retExc,
  input  logic    retBrk,
  output strobe_t strobes
);
  logic irqTake;
  assign irqTake = ieLive & irqPend;

  always_comb begin
    strobes = '0;
    strobes.excId = EXC_RESET;
    if (evBreak) begin
      strobes.take  = 1'b1;
      strobes.debug = 1'b1;
      strobes.excId = EXC_BREAK;
    end else if (evBusErr) begin
      strobes.take  = 1'b1;
      strobes.excId = EXC_DBUS;
    end else if (evDivZero) begin
      strobes.take  = 1'b1;
      strobes.excId = EXC_DIVZERO;
    end else if (evSyscall) begin
      strobes.take  = 1'b1;
      strobes.excId = EXC_SYSCALL;
    end else if (irqTake) begin
      strobes.take  = 1'b1;
      strobes.excId = EXC_IRQ;
    end
    // Returns only act when no trap claims the enable register.
    strobes.retExc = retExc & ~strobes.take;
    strobes.retBrk = retBrk & ~strobes.take & ~retExc;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && strobes.excId == EXC_IRQ) |-> (ieLive && irqPend)); // R9
  AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    evBreak |-> (strobes.take && strobes.debug && strobes.excId == EXC_BREAK)); // R10
  AST_BUSERR_OVER_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (!evBreak && evBusErr) |-> (strobes.excId == EXC_DBUS)); // R10
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_IRQ   = 8,
  parameter int VEC_SHIFT = 5,
  parameter int BASE_ALIGN = 8,
  parameter int RF_AW     = 5,
  parameter int GPR_EA    = 30,
  parameter int GPR_BA    = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [XLEN-1:0]    faultPc,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               csrWe,
  input  logic [2:0]         csrSel,
  input  logic [XLEN-1:0]    csrWdata,
  output logic               ieLive,
  output logic               irqPend,
  output logic [XLEN-1:0]    csrRdata,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               rfWe,
  output logic [RF_AW-1:0]   rfAddr,
  output logic [XLEN-1:0]    rfData
);
  localparam logic [XLEN-1:0] BASE_MASK = {XLEN{1'b1}} << BASE_ALIGN;

  logic [2:0]         ieQ, ieNext;
  logic [NUM_IRQ-1:0] imQ, ipQ, ipNext;
  logic [XLEN-1:0]    ebaQ, debaQ;
  logic               wrIe, wrIm, wrIp, wrEba, wrDeba;

  assign wrIe   = csrWe && csrSel == CSR_IE;
  assign wrIm   = csrWe && csrSel == CSR_IM;
  assign wrIp   = csrWe && csrSel == CSR_IP;
  assign wrEba  = csrWe && csrSel == CSR_EBA;
  assign wrDeba = csrWe && csrSel == CSR_DEBA;

  always_comb begin
    if (strobes.take)
      ieNext = strobes.debug ? {ieQ[0], 2'b00} : {1'b0, ieQ[0], 1'b0};
    else if (strobes.retExc)
      ieNext = {2'b00, ieQ[1]};
    else if (strobes.retBrk)
      ieNext = {2'b00, ieQ[2]};
    else if (wrIe)
      ieNext = csrWdata[2:0];
    else
      ieNext = ieQ;
  end

  always_comb begin
    ipNext = wrIp ? (ipQ & ~csrWdata[NUM_IRQ-1:0]) : ipQ;
    ipNext = ipNext | irqLines;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ   <= '0;
      imQ   <= '0;
      ipQ   <= '0;
      ebaQ  <= '0;
      debaQ <= '0;
    end else begin
      ieQ <= ieNext;
      ipQ <= ipNext;
      if (wrIm)   imQ   <= csrWdata[NUM_IRQ-1:0];
      if (wrEba)  ebaQ  <= csrWdata & BASE_MASK;
      if (wrDeba) debaQ <= csrWdata & BASE_MASK;
    end
  end

  assign ieLive  = ieQ[0];
  assign irqPend = |(ipQ & imQ);

  always_comb begin
    case (csrSel)
      CSR_IE:   csrRdata = XLEN'(ieQ);
      CSR_IM:   csrRdata = XLEN'(imQ);
      CSR_IP:   csrRdata = XLEN'(ipQ);
      CSR_EBA:  csrRdata = ebaQ;
      CSR_DEBA: csrRdata = debaQ;
      default:  csrRdata = '0;
    endcase
  end

  assign redirectValid = strobes.take;
  assign redirectPc    = (strobes.debug ? debaQ : ebaQ)
                       + (XLEN'(strobes.excId) << VEC_SHIFT);
  assign rfWe   = strobes.take;
  assign rfAddr = strobes.debug ? RF_AW'(GPR_BA) : RF_AW'(GPR_EA);
  assign rfData = faultPc;

  AST_SAVE_IE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && !strobes.debug) |=> (ieQ == {1'b0, $past(ieQ[0]), 1'b0})); // R4
  AST_SAVE_BRK: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && strobes.debug) |=> (ieQ == {$past(ieQ[0]), 2'b00})); // R5
  AST_ERET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retExc |=> (ieQ == {2'b00, $past(ieQ[1])})); // R6
  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (ebaQ[BASE_ALIGN-1:0] == '0) && (debaQ[BASE_ALIGN-1:0] == '0)); // R8
  AST_IP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrIp && irqLines == '0) |=> ((ipQ & $past(csrWdata[NUM_IRQ-1:0])) == '0)); // R7
  AST_RF_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (rfAddr == RF_AW'(GPR_EA) || rfAddr == RF_AW'(GPR_BA))); // R2
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8,
  parameter int RF_AW   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evBreak,
  input  logic               evBusErr,
  input  logic               evDivZero,
  input  logic               evSyscall,
  input  logic [XLEN-1:0]    faultPc,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               retExc,
  input  logic               retBrk,
  input  logic               csrWe,
  input  logic [2:0]         csrSel,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               rfWe,
  output logic [RF_AW-1:0]   rfAddr,
  output logic [XLEN-1:0]    rfData
);
  strobe_t strobes;
  logic    ieLive, irqPend;

  trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .evBreak(evBreak), .evBusErr(evBusErr),
    .evDivZero(evDivZero), .evSyscall(evSyscall),
    .ieLive(ieLive), .irqPend(irqPend),
    .retExc(retExc), .retBrk(retBrk),
    .strobes(strobes)
  );

  trap_regs #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .RF_AW(RF_AW)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .faultPc(faultPc), .irqLines(irqLines),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata),
    .ieLive(ieLive), .irqPend(irqPend), .csrRdata(csrRdata),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData)
  );
endmodule

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic evBreak = 0, evBusErr = 0, evDivZero = 0, evSyscall = 0;
  logic [31:0] faultPc = '0;
  logic [7:0] irqLines = '0;
  logic retExc = 0, retBrk = 0, csrWe = 0;
  logic [2:0] csrSel = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, redirectPc, rfData;
  logic redirectValid, rfWe;
  logic [4:0] rfAddr;
  int nChecks = 0, nFails = 0;
  localparam logic [31:0] EBA = 32'h1234_5600, DEBA = 32'hABCD_0000;

  trap_unit u_trap_unit (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {evBreak, evBusErr, evDivZero, evSyscall, retExc, retBrk, csrWe} = '0;
    irqLines = '0;
  endtask

  task automatic wrCsr(input logic [2:0] sel, input logic [31:0] val);
    idle();
    csrWe = 1; csrSel = sel; csrWdata = val;
    @(posedge clk);
    idle();
  endtask

  task automatic rdCsr(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csrSel = sel;
    #1 chk(tag, csrRdata, exp);
  endtask

  // Raise requests for one cycle and check the trap outputs before the edge.
  task automatic trapCycle(input logic b, input logic e, input logic d, input logic s,
                           input logic [31:0] pc, input logic [31:0] expPc,
                           input logic [4:0] expReg, input string tag);
    idle();
    evBreak = b; evBusErr = e; evDivZero = d; evSyscall = s; faultPc = pc;
    #2;
    chk({tag, " valid"}, 32'(redirectValid), 1);
    chk({tag, " pc"}, redirectPc, expPc);
    chk({tag, " rfWe"}, 32'(rfWe), 1);
    chk({tag, " rfAddr"}, 32'(rfAddr), 32'(expReg));
    chk({tag, " rfData"}, rfData, pc);
    @(posedge clk);
    idle();
  endtask

  task automatic doRet(input logic exc);
    idle();
    retExc = exc; retBrk = !exc;
    #2 chk("R6 no redirect on return", 32'(redirectValid), 0);
    @(posedge clk);
    idle();
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 redirect", 32'(redirectValid), 0);
    chk("R1 rfWe", 32'(rfWe), 0);
    for (int i = 0; i < 5; i++) rdCsr(3'(i), 0, "R1 csr");
  endtask

  task automatic testSetup();
    wrCsr(3, 32'h1234_56FF);
    rdCsr(3, EBA, "R8 eba");
    wrCsr(4, 32'hABCD_0077);
    rdCsr(4, DEBA, "R8 deba");
    wrCsr(0, 1);
    rdCsr(0, 1, "R7 ie replace");
    wrCsr(1, 32'h0F);
    rdCsr(1, 32'h0F, "R7 im replace");
  endtask

  task automatic testExceptions();
    trapCycle(0, 0, 1, 0, 32'h100, EBA + 32'hA0, 30, "R2 divzero");
    rdCsr(0, 2, "R4 ie after divzero");
    doRet(1);
    rdCsr(0, 1, "R6 eret");
    trapCycle(0, 0, 0, 1, 32'h200, EBA + 32'hE0, 30, "R2 syscall");
    rdCsr(0, 2, "R4 ie after syscall");
    doRet(1);
    trapCycle(0, 1, 0, 0, 32'h204, EBA + 32'h80, 30, "R2 buserr");
    doRet(1);
    rdCsr(0, 1, "R6 eret after buserr");
    trapCycle(1, 0, 0, 0, 32'h300, DEBA + 32'h20, 31, "R3 break");
    rdCsr(0, 4, "R5 ie after break");
    doRet(0);
    rdCsr(0, 1, "R6 bret");
  endtask

  task automatic testPriority();
    trapCycle(1, 1, 1, 1, 32'h310, DEBA + 32'h20, 31, "R10 break first");
    doRet(0);
    trapCycle(0, 1, 1, 1, 32'h320, EBA + 32'h80, 30, "R10 buserr second");
    doRet(1);
    trapCycle(0, 0, 1, 1, 32'h330, EBA + 32'hA0, 30, "R10 divzero third");
    doRet(1);
    rdCsr(0, 1, "R10 ie restored");
  endtask

  task automatic testIrq();
    wrCsr(0, 0);
    idle(); irqLines = 8'h02;
    #2 chk("R9 no take while disabled", 32'(redirectValid), 0);
    @(posedge clk);
    idle();
    #2 chk("R9 pending but disabled", 32'(redirectValid), 0);
    rdCsr(2, 32'h02, "R7 line sets pending");
    wrCsr(0, 1);
    faultPc = 32'h400;
    #2;
    chk("R9 irq valid", 32'(redirectValid), 1);
    chk("R9 irq pc", redirectPc, EBA + 32'hC0);
    chk("R9 irq reg", 32'(rfAddr), 30);
    @(posedge clk);
    idle();
    rdCsr(0, 2, "R4 ie after irq");
    wrCsr(2, 32'h02);
    rdCsr(2, 0, "R7 w1c");
    doRet(1);
    wrCsr(1, 0);
    idle(); irqLines = 8'h05;
    @(posedge clk);
    idle();
    #2 chk("R9 masked no take", 32'(redirectValid), 0);
    rdCsr(2, 32'h05, "R7 pending set");
    wrCsr(2, 32'h04);
    rdCsr(2, 32'h01, "R7 w1c partial");
    wrCsr(2, 32'hFF);
  endtask

  task automatic testConflict();
    rdCsr(0, 1, "R11 ie before");
    idle();
    evDivZero = 1; faultPc = 32'h500;
    csrWe = 1; csrSel = 0; csrWdata = 0;
    @(posedge clk);
    idle();
    rdCsr(0, 2, "R11 trap wins ie write");
    idle();
    evSyscall = 1; retExc = 1;
    @(posedge clk);
    idle();
    rdCsr(0, 0, "R11 trap wins return");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSetup();
    testExceptions();
    testPriority();
    testIrq();
    testConflict();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule